// File: doc/BRIEF.md
# Indirect Nibble Add-With-Carry Executor

This block runs one family of 4-bit arithmetic instructions. Each instruction reads a nibble from data memory, adds a 4-bit immediate from the instruction word and the incoming carry flag, and writes the 4-bit result back to the same location. The address comes from one of two 16-bit index registers. Two of the four variants also step that index register by one after the update.

A one-shot extended-address override may be pending when the instruction starts. In that case the two non-incrementing forms use a page-fixed address instead of the index register. The X form goes to page 0x00 and the Y form goes to page 0xFF, with the low byte taken from an 8-bit extension value. The post-increment forms ignore the override.

An instruction takes two clock cycles. In the first cycle the read is issued. In the second cycle the write, the flag update, any index-register update and a done pulse all happen. The index registers and flags stay outside the block: it takes their current values in and hands back the new values, each with a write enable.

Top module: `nib_adc_exec`

## Requirements
- R1: An instruction is accepted only when `instr[12:6]` is 7'b1100110. `instr[5]` selects Y (1) or X (0). `instr[4]` selects post-increment (1) or none (0). `instr[3:0]` is the immediate.
- R2: In the cycle in which `start` is high, the block is idle and the opcode matches, `mem_rd` is 1 and `mem_addr` carries the effective address. `busy` is 1 in the following cycle.
- R3: In the second cycle `mem_wr` is 1 at the same address and `mem_wdata` equals the low 4 bits of `mem_rdata + imm + C`. C is the carry flag sampled in the first cycle. `done` is high for exactly that one cycle.
- R4: While `flag_we` is 1 (the second cycle only), `flag_c_out` is 1 exactly when that 5-bit sum exceeds 15. `flag_z_out` is 1 exactly when the written nibble is zero. `flag_e_out` is 0, and `flag_i_out` equals the I flag sampled in the first cycle.
- R5: For post-increment forms, the selected index output equals the sampled index plus 1 modulo 2^16, and its write enable is high in the second cycle only. The other index register's write enable stays 0. Non-incrementing forms raise no index write enable.
- R6: With `ext_pend` at 1, the X non-incrementing form addresses {8'h00, `ext_val`} and the Y non-incrementing form addresses {8'hFF, `ext_val`}.
- R7: For the post-increment forms, `ext_pend` has no effect and the address is the selected index register.
- R8: A `start` with a non-matching opcode produces no read, no write, no `busy`, no `done` and no flag or index write enable.
- R9: A `start` during the second cycle is ignored: no read is issued in that cycle, and the block is idle in the next cycle.
- R10: The index-register step never changes the flags. A wrap from 0xFFFF to 0x0000 leaves C and Z set purely from the nibble sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction start strobe |
| instr | input | 13 | Instruction word |
| idx_x | input | 16 | Current X index register |
| idx_y | input | 16 | Current Y index register |
| ext_pend | input | 1 | Extended-address override pending |
| ext_val | input | 8 | Extension low byte |
| mem_rdata | input | 4 | Memory read data, valid the cycle after `mem_rd` |
| flag_e_in | input | 1 | Current E flag |
| flag_i_in | input | 1 | Current I flag |
| flag_c_in | input | 1 | Current carry flag |
| flag_z_in | input | 1 | Current zero flag |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 4 | Memory write data |
| flag_e_out | output | 1 | New E flag |
| flag_i_out | output | 1 | New I flag |
| flag_c_out | output | 1 | New carry flag |
| flag_z_out | output | 1 | New zero flag |
| flag_we | output | 1 | Flag write enable |
| idx_x_out | output | 16 | New X value |
| idx_x_we | output | 1 | X write enable |
| idx_y_out | output | 16 | New Y value |
| idx_y_we | output | 1 | Y write enable |
| done | output | 1 | Instruction complete pulse |
| busy | output | 1 | Second cycle in progress |

## Verification
In the second cycle the nibble add produces the flags and the index step produces the new register value. The bench drives post-increment forms with the index at 0xFFFF and memory data that carries out to a zero nibble, so both roll over in the same cycle. It then checks that C and Z follow only the nibble result while the index output wraps to 0x0000. Random runs also change the carry and I inputs during the second cycle, which shows that the flags come from the values sampled at start.

// File: rtl/nib_adc_pkg.sv
package nib_adc_pkg;

    localparam int DW      = 4;
    localparam int AW      = 16;
    localparam int EW      = 8;
    localparam int IW      = 13;
    localparam int TAG_W   = IW - 2 - DW;
    localparam logic [TAG_W-1:0] OP_TAG = 7'b1100110;
    localparam logic [AW-EW-1:0] PAGE_LO = '0;
    localparam logic [AW-EW-1:0] PAGE_HI = '1;

    typedef struct packed {
        logic          valid;
        logic          use_y;
        logic          post_inc;
        logic [DW-1:0] imm;
    } op_t;

    typedef struct packed {
        logic e;
        logic i;
        logic c;
        logic z;
    } flags_t;

    typedef enum logic {ST_IDLE, ST_EXEC} state_t;

    function automatic op_t decode_op(input logic [IW-1:0] w);
        op_t o;
        o.valid    = (w[IW-1 -: TAG_W] == OP_TAG);
        o.use_y    = w[DW+1];
        o.post_inc = w[DW];
        o.imm      = w[DW-1:0];
        return o;
    endfunction

endpackage

// File: rtl/nib_adc_decode.sv
module nib_adc_decode
    import nib_adc_pkg::*;
(
    input  logic [IW-1:0] instr,
    output op_t           op
);
    always_comb op = decode_op(instr);
endmodule

// File: rtl/nib_adc_agen.sv
module nib_adc_agen
    import nib_adc_pkg::*;
(
    input  op_t           op,
    input  logic [AW-1:0] idx_x,
    input  logic [AW-1:0] idx_y,
    input  logic          ext_pend,
    input  logic [EW-1:0] ext_val,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] idx_sel
);
    logic          use_ext;
    logic [AW-1:0] ext_addr;

    always_comb begin
        idx_sel  = op.use_y ? idx_y : idx_x;
        use_ext  = ext_pend && !op.post_inc;
        ext_addr = {(op.use_y ? PAGE_HI : PAGE_LO), ext_val};
        eff_addr = use_ext ? ext_addr : idx_sel;
    end
endmodule

// File: rtl/nib_adc_alu.sv
module nib_adc_alu
    import nib_adc_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          zero
);
    logic [DW:0] sum;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        res  = sum[DW-1:0];
        cout = sum[DW];
        zero = (sum[DW-1:0] == '0);
    end
endmodule

// File: rtl/nib_adc_exec.sv
module nib_adc_exec
    import nib_adc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [12:0]   instr,
    input  logic [15:0]   idx_x,
    input  logic [15:0]   idx_y,
    input  logic          ext_pend,
    input  logic [7:0]    ext_val,
    input  logic [3:0]    mem_rdata,
    input  logic          flag_e_in,
    input  logic          flag_i_in,
    input  logic          flag_c_in,
    input  logic          flag_z_in,
    output logic [15:0]   mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [3:0]    mem_wdata,
    output logic          flag_e_out,
    output logic          flag_i_out,
    output logic          flag_c_out,
    output logic          flag_z_out,
    output logic          flag_we,
    output logic [15:0]   idx_x_out,
    output logic          idx_x_we,
    output logic [15:0]   idx_y_out,
    output logic          idx_y_we,
    output logic          done,
    output logic          busy
);
    state_t        state_q;
    op_t           dec_op, op_q;
    logic [AW-1:0] eff_addr, idx_sel, addr_q, idx_q, idx_next;
    logic          cin_q, iflag_q, launch, exec;
    logic [DW-1:0] alu_res;
    logic          alu_cout, alu_zero;
    flags_t        flags_new;

    nib_adc_decode u_dec (
        .instr (instr),
        .op    (dec_op)
    );

    nib_adc_agen u_agen (
        .op       (dec_op),
        .idx_x    (idx_x),
        .idx_y    (idx_y),
        .ext_pend (ext_pend),
        .ext_val  (ext_val),
        .eff_addr (eff_addr),
        .idx_sel  (idx_sel)
    );

    nib_adc_alu u_alu (
        .a    (mem_rdata),
        .b    (op_q.imm),
        .cin  (cin_q),
        .res  (alu_res),
        .cout (alu_cout),
        .zero (alu_zero)
    );

    assign exec   = (state_q == ST_EXEC);
    assign launch = start && (state_q == ST_IDLE) && dec_op.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            addr_q  <= '0;
            idx_q   <= '0;
            cin_q   <= 1'b0;
            iflag_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (launch) begin
                    state_q <= ST_EXEC;
                    op_q    <= dec_op;
                    addr_q  <= eff_addr;
                    idx_q   <= idx_sel;
                    cin_q   <= flag_c_in;
                    iflag_q <= flag_i_in;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idx_next        = idx_q + 16'd1;
        flags_new.e     = 1'b0;
        flags_new.i     = iflag_q;
        flags_new.c     = alu_cout;
        flags_new.z     = alu_zero;
        mem_rd          = launch;
        mem_wr          = exec;
        mem_addr        = exec ? addr_q : eff_addr;
        mem_wdata       = alu_res;
        flag_we         = exec;
        flag_e_out      = exec ? flags_new.e : flag_e_in;
        flag_i_out      = exec ? flags_new.i : flag_i_in;
        flag_c_out      = exec ? flags_new.c : flag_c_in;
        flag_z_out      = exec ? flags_new.z : flag_z_in;
        idx_x_we        = exec && op_q.post_inc && !op_q.use_y;
        idx_y_we        = exec && op_q.post_inc && op_q.use_y;
        idx_x_out       = idx_x_we ? idx_next : idx_x;
        idx_y_out       = idx_y_we ? idx_next : idx_y;
        done            = exec;
        busy            = exec;
    end

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> mem_wr); // R3
    AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (mem_addr == $past(mem_addr))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R9
    AST_E_CLEARED: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> !flag_e_out); // R4
    AST_I_KEPT: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (flag_i_out == $past(flag_i_in))); // R4
    AST_IDX_ONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({idx_x_we, idx_y_we})); // R5
    AST_IDX_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (idx_x_we || idx_y_we) |-> done); // R5
    AST_BAD_OP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !mem_rd) |=> !busy); // R8
    AST_EXT_PAGE_X: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && ext_pend && !instr[5] && !instr[4]) |-> (mem_addr[15:8] == 8'h00)); // R6
    AST_EXT_PAGE_Y: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && ext_pend && instr[5] && !instr[4]) |-> (mem_addr[15:8] == 8'hFF)); // R6
    AST_INC_NO_EXT: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && instr[4]) |-> (mem_addr == (instr[5] ? idx_y : idx_x))); // R7
endmodule

// File: tb/test_nib_adc_exec.sv
module test_nib_adc_exec;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [12:0] instr;
    logic [15:0] idx_x, idx_y;
    logic        ext_pend;
    logic [7:0]  ext_val;
    logic [3:0]  mem_rdata;
    logic        flag_e_in, flag_i_in, flag_c_in, flag_z_in;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [3:0]  mem_wdata;
    logic        flag_e_out, flag_i_out, flag_c_out, flag_z_out, flag_we;
    logic [15:0] idx_x_out, idx_y_out;
    logic        idx_x_we, idx_y_we, done, busy;

    int checks = 0;
    int errors = 0;
    logic [3:0] mem [256];

    always #5 clk = ~clk;

    nib_adc_exec i_nib_adc_exec (
        .clk(clk), .rst(rst), .start(start), .instr(instr),
        .idx_x(idx_x), .idx_y(idx_y), .ext_pend(ext_pend), .ext_val(ext_val),
        .mem_rdata(mem_rdata), .flag_e_in(flag_e_in), .flag_i_in(flag_i_in),
        .flag_c_in(flag_c_in), .flag_z_in(flag_z_in), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .flag_e_out(flag_e_out), .flag_i_out(flag_i_out), .flag_c_out(flag_c_out),
        .flag_z_out(flag_z_out), .flag_we(flag_we), .idx_x_out(idx_x_out),
        .idx_x_we(idx_x_we), .idx_y_out(idx_y_out), .idx_y_we(idx_y_we),
        .done(done), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_addr(input logic [12:0] w, input logic [15:0] x,
                                             input logic [15:0] y, input logic pend,
                                             input logic [7:0] e);
        if (pend && !w[4]) return w[5] ? {8'hFF, e} : {8'h00, e};
        return w[5] ? y : x;
    endfunction

    function automatic logic [4:0] exp_sum(input logic [3:0] d, input logic [3:0] imm,
                                           input logic c);
        return {1'b0, d} + {1'b0, imm} + {4'd0, c};
    endfunction

    task automatic run_op(input logic [12:0] w, input logic [15:0] x, input logic [15:0] y,
                          input logic pend, input logic [7:0] e, input logic [3:0] fl,
                          input logic hold);
        logic        ok_op;
        logic [15:0] ea;
        logic [3:0]  d;
        logic [4:0]  s;
        @(negedge clk);
        instr = w; idx_x = x; idx_y = y; ext_pend = pend; ext_val = e;
        {flag_e_in, flag_i_in, flag_c_in, flag_z_in} = fl;
        start = 1'b1;
        ok_op = (w[12:6] == 7'b1100110);
        ea = exp_addr(w, x, y, pend, e);
        d  = mem[ea[7:0]];
        s  = exp_sum(d, w[3:0], fl[1]);
        #1;
        if (ok_op) begin
            chk(mem_rd == 1'b1, "R2 read strobe", mem_rd, 1);
            chk(mem_addr == ea, (pend && !w[4]) ? "R6 ext address" :
                (pend ? "R7 ext ignored address" : "R1 R2 address"), mem_addr, ea);
        end else begin
            chk(mem_rd == 1'b0, "R8 no read", mem_rd, 0);
        end
        @(negedge clk);
        if (!hold) start = 1'b0;
        flag_c_in = ~fl[1];
        flag_i_in = ~fl[2];
        #1;
        if (ok_op) begin
            chk(busy && done && mem_wr, "R3 second cycle strobes", {busy, done, mem_wr}, 7);
            chk(mem_addr == ea, "R3 write address", mem_addr, ea);
            chk(mem_wdata == s[3:0], "R3 write data", mem_wdata, s[3:0]);
            chk(flag_we && flag_c_out == s[4] && flag_z_out == (s[3:0] == 4'd0),
                "R4 R10 carry zero", {flag_we, flag_c_out, flag_z_out},
                {1'b1, s[4], s[3:0] == 4'd0});
            chk(!flag_e_out && flag_i_out == fl[2], "R4 E clear I kept",
                {flag_e_out, flag_i_out}, {1'b0, fl[2]});
            chk(idx_x_we == (w[4] && !w[5]) && idx_y_we == (w[4] && w[5]),
                "R5 index enables", {idx_x_we, idx_y_we}, {w[4] && !w[5], w[4] && w[5]});
            if (w[4] && !w[5]) chk(idx_x_out == x + 16'd1, "R5 X step", idx_x_out, x + 16'd1);
            if (w[4] && w[5])  chk(idx_y_out == y + 16'd1, "R5 Y step", idx_y_out, y + 16'd1);
            if (hold) chk(mem_rd == 1'b0, "R9 no read while busy", mem_rd, 0);
        end else begin
            chk(!busy && !done && !mem_wr && !flag_we && !idx_x_we && !idx_y_we,
                "R8 ignored", {busy, done, mem_wr, flag_we}, 0);
        end
        if (hold) begin
            @(negedge clk);
            start = 1'b0;
            #1;
            chk(!busy && !done, "R9 idle after busy start", {busy, done}, 0);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) mem[i] = 4'(i * 7 + 3);
        rst = 1'b1; start = 1'b0; instr = '0; idx_x = '0; idx_y = '0;
        ext_pend = 1'b0; ext_val = '0; mem_rdata = '0;
        {flag_e_in, flag_i_in, flag_c_in, flag_z_in} = 4'b1010;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!busy && !done && !mem_rd && !mem_wr && !flag_we, "R2 reset idle",
            {busy, done, mem_rd, mem_wr}, 0);

        // Directed: index wrap together with nibble carry to zero (R10, R5)
        mem[8'hFF] = 4'hF;
        run_op(13'h1991, 16'hFFFF, 16'h1234, 1'b0, 8'h00, 4'b1000, 1'b0);
        mem[8'hFF] = 4'hE;
        run_op(13'h19B1, 16'h0000, 16'hFFFF, 1'b1, 8'h40, 4'b0010, 1'b0); // R7 R10
        // Directed: extended addressing both pages (R6)
        run_op(13'h1985, 16'h5A5A, 16'h0303, 1'b1, 8'h7C, 4'b0000, 1'b0);
        run_op(13'h19AF, 16'h5A5A, 16'h0303, 1'b1, 8'h11, 4'b0110, 1'b0);
        // Directed: non-matching opcodes (R8, R1)
        run_op(13'h19C0, 16'h0010, 16'h0020, 1'b0, 8'h00, 4'b0000, 1'b0);
        run_op(13'h1880, 16'h0010, 16'h0020, 1'b1, 8'h33, 4'b0000, 1'b0);
        // Directed: start held into second cycle (R9)
        run_op(13'h1993, 16'h0042, 16'h0099, 1'b0, 8'h00, 4'b0100, 1'b1);

        for (int n = 0; n < 400; n++) begin
            logic [12:0] w;
            w = {7'b1100110, 6'($urandom)};
            if ($urandom_range(0, 9) == 0) w = 13'($urandom);
            run_op(w, 16'($urandom), 16'($urandom), 1'($urandom), 8'($urandom),
                   4'($urandom), ($urandom_range(0, 7) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule